// File: doc/BRIEF.md
# Page Reference Counter Migration Detector

This block runs beside a directory lookup and keeps, for every memory page, a small array of access counters with one slot per requesting node. On each accepted request it reads the requester's slot and the home node's slot for the same page in one cycle. It writes back the requester's count plus one. It then compares how far the requester's count has moved ahead of the home count with a threshold that software programs.

When the lead is larger than the threshold, and the requester's slot is marked as a migration candidate, the block raises a one-cycle interrupt pulse toward the home node. The pulse carries the page and the node that caused it, which gives the operating system a hint that the page would be better placed elsewhere.

In large systems several nodes fold into one shared slot. A software write port clears or loads counter entries and sets the threshold.

Top module: `pgref_migr_top`

## Requirements
- R1: During and after reset `irq_pulse` is 0, `irq_page` and `irq_node` are 0, and the threshold is all ones (4095). With that threshold no request can raise an interrupt, even with a candidate slot at 4095 and a home slot at 0.
- R2: A node maps to slot `node` when NODES is at most 64. Otherwise it maps to slot `node / 8`, so nodes 8k to 8k+7 share one counter. With the default NODES=128 there are 16 slots.
- R3: A request is accepted when `req_valid` is 1 and `sw_we` is 0. It adds one to the requester slot of `req_page` in that same cycle, so back-to-back requests see each other's increments.
- R4: Counters are 12 bits wide and saturate at 4095: a further request leaves the count at 4095 and does not wrap to 0.
- R5: `irq_pulse` is 1 in the cycle after an accepted request only if all three of these hold: the requester slot's candidate bit is 1, the requester and home slots differ, and (requester count after the increment) minus (home count) is strictly greater than the threshold.
- R6: The difference is signed, so no interrupt fires when the home count is greater than or equal to the requester's incremented count.
- R7: A request whose requester slot equals its home slot never raises an interrupt. This covers a node requesting its own home page and, when slots fold, a node in the home node's group. The counter is still incremented.
- R8: On a pulse, `irq_page` and `irq_node` take the request's page and requester node. They hold their value in every other cycle.
- R9: A software write loads the threshold from `sw_data` when `sw_sel` is 0. When `sw_sel` is 1 it writes entry (`sw_page`, `sw_slot`) with count `sw_data` and candidate bit `sw_cand` (a clear is a load of 0). The write affects requests in later cycles.
- R10: When `sw_we` and `req_valid` are both 1 in one cycle, the software write wins and the request is discarded: no increment and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe from the directory lookup |
| req_page | input | PG_W (3) | Page index of the request |
| req_node | input | NODE_W (7) | Requesting node |
| home_node | input | NODE_W (7) | Home node of the page |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 1 | 0: threshold load, 1: counter entry load |
| sw_page | input | PG_W (3) | Page of the entry written |
| sw_slot | input | SLOT_W (4) | Counter slot of the entry written |
| sw_cand | input | 1 | Candidate bit for the entry written |
| sw_data | input | CNT_W (12) | Threshold or count value |
| irq_pulse | output | 1 | One-cycle migration interrupt |
| irq_page | output | PG_W (3) | Page of the last interrupt |
| irq_node | output | NODE_W (7) | Requester of the last interrupt |

Counter storage is not reset. Software initializes every entry through the write port before use.

## Verification
A vector table sweeps the requester lead around the threshold: one above, exactly equal, a negative lead, and a zero lead. This separates a strict compare from a non-strict one and a signed difference from an unsigned one. The same table toggles the candidate bit and pairs nodes that share a slot with nodes in neighbouring groups, which shows the folding and the same-slot suppression. Directed sequences follow. Repeated requests on one entry show that increments accumulate. A load of 4095 shows saturation rather than wrap. A request in the same cycle as a threshold write is proven discarded by the cycle in which a later request first fires.

// File: rtl/pgref_pkg.sv
package pgref_pkg;
  typedef enum logic {
    SW_THRESH = 1'b0,
    SW_ENTRY  = 1'b1
  } sw_sel_e;
endpackage

// File: rtl/pgref_slot_map.sv
module pgref_slot_map #(
  parameter int NODES      = 128,
  parameter int FOLD_LIMIT = 64,
  parameter int GROUP      = 8,
  parameter int NODE_W     = 7,
  parameter int SLOT_W     = 4
) (
  input  logic [NODE_W-1:0] node,
  output logic [SLOT_W-1:0] slot
);
  generate
    if (NODES > FOLD_LIMIT) begin : g_fold
      // groups of GROUP nodes share one counter
      assign slot = SLOT_W'(node / NODE_W'(GROUP));
    end else begin : g_flat
      assign slot = SLOT_W'(node);
    end
  endgenerate
endmodule

// File: rtl/pgref_store.sv
module pgref_store #(
  parameter int ADDR_W = 7,
  parameter int DW     = 13,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DW-1:0]     rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DW-1:0]     rdata_b
);
  // distributed RAM: one synchronous write, two asynchronous reads
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/pgref_decide.sv
module pgref_decide #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] cur_cnt,
  input  logic [CNT_W-1:0] home_cnt,
  input  logic [CNT_W-1:0] thr,
  input  logic             cand,
  input  logic             same_slot,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W:0] lead;

  always_comb begin
    nxt_cnt = (cur_cnt == CMAX) ? CMAX : cur_cnt + 1'b1;
    lead    = {1'b0, nxt_cnt} - {1'b0, home_cnt};
    hit     = cand && !same_slot && ($signed(lead) > $signed({1'b0, thr}));
  end
endmodule

// File: rtl/pgref_migr_top.sv
module pgref_migr_top
  import pgref_pkg::*;
#(
  parameter int PAGES      = 8,
  parameter int NODES      = 128,
  parameter int CNT_W      = 12,
  parameter int FOLD_LIMIT = 64,
  parameter int GROUP      = 8,
  localparam int SLOTS  = (NODES > FOLD_LIMIT) ? NODES / GROUP : NODES,
  localparam int PG_W   = $clog2(PAGES),
  localparam int NODE_W = $clog2(NODES),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ADDR_W = PG_W + SLOT_W,
  localparam int EW     = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [PG_W-1:0]   req_page,
  input  logic [NODE_W-1:0] req_node,
  input  logic [NODE_W-1:0] home_node,
  input  logic              sw_we,
  input  logic              sw_sel,
  input  logic [PG_W-1:0]   sw_page,
  input  logic [SLOT_W-1:0] sw_slot,
  input  logic              sw_cand,
  input  logic [CNT_W-1:0]  sw_data,
  output logic              irq_pulse,
  output logic [PG_W-1:0]   irq_page,
  output logic [NODE_W-1:0] irq_node
);
  logic [SLOT_W-1:0] req_slot, home_slot;
  logic [EW-1:0]     ent_req, ent_home, wdata;
  logic [ADDR_W-1:0] waddr;
  logic              we, acc_hw, hit;
  logic [CNT_W-1:0]  req_cnt, nxt_cnt, thr_q;

  pgref_slot_map #(.NODES(NODES), .FOLD_LIMIT(FOLD_LIMIT), .GROUP(GROUP),
                   .NODE_W(NODE_W), .SLOT_W(SLOT_W))
    u_map_req (.node(req_node), .slot(req_slot));

  pgref_slot_map #(.NODES(NODES), .FOLD_LIMIT(FOLD_LIMIT), .GROUP(GROUP),
                   .NODE_W(NODE_W), .SLOT_W(SLOT_W))
    u_map_home (.node(home_node), .slot(home_slot));

  // a software write owns the write port and discards a same-cycle request
  assign acc_hw = req_valid && !sw_we;
  assign we     = sw_we ? (sw_sel == SW_ENTRY) : acc_hw;
  assign waddr  = sw_we ? {sw_page, sw_slot} : {req_page, req_slot};
  assign wdata  = sw_we ? {sw_cand, sw_data} : {ent_req[CNT_W], nxt_cnt};

  pgref_store #(.ADDR_W(ADDR_W), .DW(EW)) u_store (
    .clk    (clk),
    .we     (we),
    .waddr  (waddr),
    .wdata  (wdata),
    .raddr_a({req_page, req_slot}),
    .rdata_a(ent_req),
    .raddr_b({req_page, home_slot}),
    .rdata_b(ent_home)
  );

  assign req_cnt = ent_req[CNT_W-1:0];

  pgref_decide #(.CNT_W(CNT_W)) u_dec (
    .cur_cnt  (req_cnt),
    .home_cnt (ent_home[CNT_W-1:0]),
    .thr      (thr_q),
    .cand     (ent_req[CNT_W]),
    .same_slot(req_slot == home_slot),
    .nxt_cnt  (nxt_cnt),
    .hit      (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= '1;
    end else if (sw_we && sw_sel == SW_THRESH) begin
      thr_q <= sw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse <= 1'b0;
      irq_page  <= '0;
      irq_node  <= '0;
    end else begin
      irq_pulse <= acc_hw && hit;
      if (acc_hw && hit) begin
        irq_page <= req_page;
        irq_node <= req_node;
      end
    end
  end
endmodule

// File: rtl/pgref_migr_chk.sv
module pgref_migr_chk #(
  parameter int PG_W   = 3,
  parameter int NODE_W = 7,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              sw_we,
  input logic [PG_W-1:0]   req_page,
  input logic [NODE_W-1:0] req_node,
  input logic [NODE_W-1:0] home_node,
  input logic              irq_pulse,
  input logic [PG_W-1:0]   irq_page,
  input logic [NODE_W-1:0] irq_node,
  input logic              acc_hw,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic [CNT_W-1:0]  nxt_cnt
);
  assert_sw_wins_R10: assert property (@(posedge clk) disable iff (rst)
    $past(sw_we) |-> !irq_pulse);

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(req_valid));

  assert_home_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && req_node == home_node) |-> !irq_pulse);

  assert_tag_load_R8: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (irq_page == $past(req_page) && irq_node == $past(req_node)));

  assert_tag_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_pulse |-> ($stable(irq_page) && $stable(irq_node)));

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    acc_hw |-> (nxt_cnt >= cur_cnt && nxt_cnt != '0));
endmodule

bind pgref_migr_top pgref_migr_chk #(.PG_W(PG_W), .NODE_W(NODE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .sw_we(sw_we),
  .req_page(req_page), .req_node(req_node), .home_node(home_node),
  .irq_pulse(irq_pulse), .irq_page(irq_page), .irq_node(irq_node),
  .acc_hw(acc_hw), .cur_cnt(req_cnt), .nxt_cnt(nxt_cnt)
);

// File: tb/sim_pgref_migr_top.sv
module sim_pgref_migr_top;
  localparam int PG_W = 3, NODE_W = 7, SLOT_W = 4, CNT_W = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, sw_we = 1'b0, sw_sel = 1'b0, sw_cand = 1'b0;
  logic [PG_W-1:0]   req_page = '0, sw_page = '0;
  logic [NODE_W-1:0] req_node = '0, home_node = '0;
  logic [SLOT_W-1:0] sw_slot = '0;
  logic [CNT_W-1:0]  sw_data = '0;
  logic              irq_pulse;
  logic [PG_W-1:0]   irq_page;
  logic [NODE_W-1:0] irq_node;

  int checks = 0, failures = 0;
  logic got;

  always #10 clk = ~clk;

  pgref_migr_top u0 (.*);

  typedef struct packed {
    logic [11:0] rc;
    logic [11:0] hc;
    logic        cand;
    logic [11:0] thr;
    logic [6:0]  rn;
    logic [6:0]  hn;
    logic        exp_irq;
  } vec_t;

  // slot = node / 8 at the default NODES=128
  localparam vec_t VEC [10] = '{
    '{12'd10,   12'd2,  1'b1, 12'd5,    7'd20, 7'd40, 1'b1}, // R5 lead 9 > 5
    '{12'd10,   12'd2,  1'b1, 12'd8,    7'd20, 7'd40, 1'b1}, // R5 lead 9 > 8
    '{12'd10,   12'd2,  1'b1, 12'd9,    7'd20, 7'd40, 1'b0}, // R5 lead 9 == thr
    '{12'd10,   12'd2,  1'b0, 12'd0,    7'd20, 7'd40, 1'b0}, // R5 not candidate
    '{12'd3,    12'd10, 1'b1, 12'd0,    7'd60, 7'd5,  1'b0}, // R6 negative lead
    '{12'd5,    12'd6,  1'b1, 12'd0,    7'd60, 7'd5,  1'b0}, // R6 zero lead
    '{12'd100,  12'd0,  1'b1, 12'd0,    7'd17, 7'd22, 1'b0}, // R7 same group
    '{12'd100,  12'd0,  1'b1, 12'd0,    7'd50, 7'd50, 1'b0}, // R7 own home
    '{12'd0,    12'd0,  1'b1, 12'd0,    7'd8,  7'd0,  1'b1}, // R2 neighbouring groups
    '{12'd4095, 12'd0,  1'b1, 12'd4094, 7'd90, 7'd3,  1'b1}  // R4 saturated lead
  };

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic sw_thr(input int v);
    sw_we = 1'b1; sw_sel = 1'b0; sw_data = CNT_W'(v);
    @(posedge clk); @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_ent(input int pg, input int sl, input int cnt, input logic cd);
    sw_we = 1'b1; sw_sel = 1'b1; sw_page = PG_W'(pg); sw_slot = SLOT_W'(sl);
    sw_data = CNT_W'(cnt); sw_cand = cd;
    @(posedge clk); @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic do_req(input int pg, input int rn, input int hn, output logic irq);
    req_valid = 1'b1; req_page = PG_W'(pg);
    req_node = NODE_W'(rn); home_node = NODE_W'(hn);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    irq = irq_pulse;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 irq_pulse in reset", int'(irq_pulse), 0);
    rst = 1'b0;
    chk("R1 irq_page after reset", int'(irq_page), 0);
    for (int p = 0; p < 8; p++)
      for (int s = 0; s < 16; s++) sw_ent(p, s, 0, 1'b0);

    // R1: reset threshold 4095 blocks even the largest lead
    sw_ent(0, 1, 4095, 1'b1);
    do_req(0, 8, 0, got);
    chk("R1 no irq at reset threshold", int'(got), 0);

    for (int i = 0; i < 10; i++) begin
      sw_thr(int'(VEC[i].thr));
      sw_ent(i % 8, int'(VEC[i].hn) / 8, int'(VEC[i].hc), 1'b0);
      sw_ent(i % 8, int'(VEC[i].rn) / 8, int'(VEC[i].rc), VEC[i].cand);
      do_req(i % 8, int'(VEC[i].rn), int'(VEC[i].hn), got);
      chk($sformatf("R5 vector %0d", i), int'(got), int'(VEC[i].exp_irq));
    end

    // R3: increments accumulate across back-to-back requests
    sw_thr(2);
    sw_ent(2, 12, 0, 1'b0);
    sw_ent(2, 3, 0, 1'b1);
    do_req(2, 30, 100, got); chk("R3 count 1", int'(got), 0);
    do_req(2, 30, 100, got); chk("R3 count 2", int'(got), 0);
    do_req(2, 30, 100, got); chk("R3 count 3 fires", int'(got), 1);
    chk("R8 irq_page loaded", int'(irq_page), 2);
    chk("R8 irq_node loaded", int'(irq_node), 30);
    do_req(5, 9, 40, got);
    chk("R8 quiet request", int'(got), 0);
    chk("R8 irq_page held", int'(irq_page), 2);
    chk("R8 irq_node held", int'(irq_node), 30);

    // R2: nodes 16 and 23 share slot 2
    sw_thr(1);
    sw_ent(4, 0, 0, 1'b0);
    sw_ent(4, 2, 0, 1'b1);
    do_req(4, 16, 0, got); chk("R2 first of group", int'(got), 0);
    do_req(4, 23, 0, got); chk("R2 shared count fires", int'(got), 1);

    // R4: saturation holds the lead at 4095 rather than wrapping
    sw_thr(4094);
    sw_ent(6, 0, 0, 1'b0);
    sw_ent(6, 9, 4095, 1'b1);
    do_req(6, 72, 1, got); chk("R4 at max", int'(got), 1);
    do_req(6, 72, 1, got); chk("R4 stays max", int'(got), 1);

    // R10 and R9: request in the cycle of a threshold write is dropped
    sw_ent(7, 0, 0, 1'b0);
    sw_ent(7, 5, 5, 1'b1);
    sw_we = 1'b1; sw_sel = 1'b0; sw_data = 12'd6;
    req_valid = 1'b1; req_page = 3'd7; req_node = 7'd44; home_node = 7'd2;
    @(posedge clk); @(negedge clk);
    sw_we = 1'b0; req_valid = 1'b0;
    chk("R10 collided request no irq", int'(irq_pulse), 0);
    do_req(7, 44, 2, got); chk("R10 count was not bumped", int'(got), 0);
    do_req(7, 44, 2, got); chk("R9 new threshold 6 applies", int'(got), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule